// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream that a controller sends to a four-bank SDRAM and keeps its own copy of each bank's state. For every bank it reports whether a row is open and which 13-bit row that is. It also follows writes that close their bank on their own: such a write starts a countdown equal to the programmed burst, and the bank is shown closed once the last beat has gone by. Until a mode-register load has been seen, the block accepts nothing else. Any command that breaks the protocol is refused, which means the bank state does not change, and it raises a sticky error flag.

Each bank is a small state machine with three states. `BK_CLOSED` moves to `BK_OPEN` on an accepted activate. `BK_OPEN` moves to `BK_CLOSING` on an accepted auto-precharge write, and back to `BK_CLOSED` on a precharge. `BK_CLOSING` moves to `BK_CLOSED` when its beat counter expires or when a precharge arrives. A global mode machine moves from `MODE_UNSET` to `MODE_READY` on the first accepted mode-register load, and only a reset takes it back. All outputs are registered, and each command is sampled on the rising clock edge.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A synchronous active-high reset clears all open flags, `mode_valid` and `proto_err`. Every output reflects a command from the clock edge that sampled it.
- R2: Before `mode_valid` is set, any command other than NOP or MRS sets `proto_err` and leaves every bank closed. NOP before that point raises no error.
- R3: An MRS is accepted only when all banks are closed and `addr[2]` is 0. It then sets `mode_valid`, takes the burst code from `addr[1:0]` (0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8) and the single-write select from `addr[9]` (1 means every write is one beat). Any other MRS sets `proto_err` and changes nothing.
- R4: The bank index is {`bank_sel_msb`, `bank_sel_lsb`}. So (0,0) selects bank 0, (0,1) bank 1, (1,0) bank 2 and (1,1) bank 3. Bank i is reported on `bank_open[i]` and `bank_rows[13*i +: 13]`.
- R5: ACTV to a closed bank sets its open flag and stores `addr` as its row. ACTV to a bank that is open or closing sets `proto_err` and leaves the stored row unchanged.
- R6: READ or WRIT to a bank that is not in the open state sets `proto_err`. To an open bank, it leaves the bank open and raises no error.
- R7: WRITA to an open bank closes it L clocks after the sampling edge, where L is the burst length, or 1 in single-write mode. While the bank is closing, READ, WRIT, WRITA and ACTV to it set `proto_err`.
- R8: PRE closes only the selected bank, including a bank that is closing. PRE to a bank that is already closed raises no error.
- R9: PALL closes all four banks.
- R10: REF, in its auto or self form, sets `proto_err` if any bank is open. With all banks closed it has no effect.
- R11: Once set, `proto_err` stays set until reset.
- R12: The command codes are NOP=0, ACTV=1, READ=2, WRIT=3, WRITA=4, PRE=5, PALL=6, REF=7 and MRS=8. Codes 9 to 15 set `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 4 | Decoded command (R12 encoding) |
| bank_sel_msb | input | 1 | Upper bank-select bit |
| bank_sel_lsb | input | 1 | Lower bank-select bit |
| addr | input | 13 | Row for ACTV, mode value for MRS, column in bits 9:0 for reads and writes |
| bank_open | output | 4 | Open flag per bank |
| bank_rows | output | 52 | Stored row per bank, 13 bits each |
| mode_valid | output | 1 | A legal mode-register load has been seen |
| proto_err | output | 1 | Sticky protocol error |

## Verification
Open flags, rows, `mode_valid` and `proto_err` are all due one clock after the edge that samples a command. The bench drives each command on a falling edge and reads the results on the next falling edge, half a period after the edge that updates them. For an auto-precharge write of length L, the bank's flag is checked as open at each of the L−1 falling edges that follow the first read, and as closed at the L-th. This places the closing edge exactly, for L of 1, 2, 4 and 8 and for single-write mode.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_WRAP = 4'd4,
        CMD_PRE  = 4'd5,
        CMD_PALL = 4'd6,
        CMD_REF  = 4'd7,
        CMD_MRS  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {BK_CLOSED, BK_OPEN, BK_CLOSING} bank_st_e;
    typedef enum logic {MODE_UNSET, MODE_READY} mode_st_e;
endpackage

// File: rtl/sbt_mode.sv
module sbt_mode
    import sbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mrs_i,
    input  logic [1:0]       code_i,
    input  logic             single_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] beats_o
);
    mode_st_e   st_q, st_d;
    logic [1:0] code_q;
    logic       single_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_UNSET: if (mrs_i) st_d = MODE_READY;
            MODE_READY: st_d = MODE_READY;
            default:    st_d = MODE_UNSET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= MODE_UNSET;
            code_q   <= 2'd0;
            single_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (mrs_i) begin
                code_q   <= code_i;
                single_q <= single_i;
            end
        end
    end

    always_comb begin
        valid_o = (st_q == MODE_READY);
        beats_o = single_q ? CNT_W'(1) : (CNT_W'(1) << code_q);
    end

    assert_mode_held_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);
endmodule

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
    import sbt_pkg::*;
(
    input  logic [3:0]       cmd_i,
    input  logic [BANK_W-1:0] sel_i,
    input  logic             burst_hi_i,
    input  logic             mode_valid_i,
    input  logic [NBANK-1:0] open_i,
    input  logic [NBANK-1:0] ready_i,
    output logic             err_o,
    output logic [NBANK-1:0] act_o,
    output logic [NBANK-1:0] pre_o,
    output logic [NBANK-1:0] ap_o,
    output logic             mrs_o
);
    logic [NBANK-1:0] hot;

    always_comb begin
        hot = '0;
        hot[sel_i] = 1'b1;
        err_o = 1'b0;
        act_o = '0;
        pre_o = '0;
        ap_o  = '0;
        mrs_o = 1'b0;
        if (!mode_valid_i && cmd_i != CMD_NOP && cmd_i != CMD_MRS) begin
            err_o = 1'b1;
        end else begin
            case (cmd_i)
                CMD_NOP:  ;
                CMD_ACT:  if (open_i[sel_i]) err_o = 1'b1; else act_o = hot;
                CMD_RD,
                CMD_WR:   if (!ready_i[sel_i]) err_o = 1'b1;
                CMD_WRAP: if (!ready_i[sel_i]) err_o = 1'b1; else ap_o = hot;
                CMD_PRE:  pre_o = hot;
                CMD_PALL: pre_o = '1;
                CMD_REF:  if (|open_i) err_o = 1'b1;
                CMD_MRS:  if ((|open_i) || burst_hi_i) err_o = 1'b1; else mrs_o = 1'b1;
                default:  err_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             ap_i,
    input  logic [CNT_W-1:0] beats_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic             ready_o,
    output logic [ROW_W-1:0] row_o
);
    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_CLOSED:  if (act_i) st_d = BK_OPEN;
            BK_OPEN:    if (pre_i) st_d = BK_CLOSED;
                        else if (ap_i) st_d = BK_CLOSING;
            BK_CLOSING: if (pre_i || cnt_q == CNT_W'(1)) st_d = BK_CLOSED;
            default:    st_d = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_CLOSED;
            cnt_q <= '0;
            row_o <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == BK_OPEN && ap_i)
                cnt_q <= beats_i;
            else if (st_q == BK_CLOSING && cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
            if (st_q == BK_CLOSED && act_i)
                row_o <= row_i;
        end
    end

    always_comb begin
        open_o  = (st_q != BK_CLOSED);
        ready_o = (st_q == BK_OPEN);
    end

    assert_act_opens_R5: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (open_o && row_o == $past(row_i)));
    assert_pre_closes_R8: assert property (@(posedge clk) disable iff (rst)
        pre_i |=> !open_o);
    assert_ap_closing_R7: assert property (@(posedge clk) disable iff (rst)
        (ap_i && beats_i > CNT_W'(1)) |=> (open_o && !ready_o));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             cmd_code,
    input  logic                   bank_sel_msb,
    input  logic                   bank_sel_lsb,
    input  logic [ROW_W-1:0]       addr,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] bank_rows,
    output logic                   mode_valid,
    output logic                   proto_err
);
    logic [NBANK-1:0] ready_w, act_w, pre_w, ap_w;
    logic             err_w, mrs_w;
    logic [CNT_W-1:0] beats_w;
    logic [ROW_W-1:0] row_w [NBANK];

    sbt_cmd_decode u_dec (
        .cmd_i        (cmd_code),
        .sel_i        ({bank_sel_msb, bank_sel_lsb}),
        .burst_hi_i   (addr[2]),
        .mode_valid_i (mode_valid),
        .open_i       (bank_open),
        .ready_i      (ready_w),
        .err_o        (err_w),
        .act_o        (act_w),
        .pre_o        (pre_w),
        .ap_o         (ap_w),
        .mrs_o        (mrs_w)
    );

    sbt_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .mrs_i    (mrs_w),
        .code_i   (addr[1:0]),
        .single_i (addr[9]),
        .valid_o  (mode_valid),
        .beats_o  (beats_w)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sbt_bank #(.ROW_W(ROW_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act_i   (act_w[b]),
            .pre_i   (pre_w[b]),
            .ap_i    (ap_w[b]),
            .beats_i (beats_w),
            .row_i   (addr),
            .open_o  (bank_open[b]),
            .ready_o (ready_w[b]),
            .row_o   (row_w[b])
        );
        assign bank_rows[b*ROW_W +: ROW_W] = row_w[b];
    end

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= proto_err | err_w;
    end

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
    assert_closed_until_mode_R2: assert property (@(posedge clk) disable iff (rst)
        !mode_valid |-> (bank_open == '0));
    assert_bad_burst_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_MRS && addr[2]) |=> proto_err);
    assert_ref_open_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_REF && (|bank_open)) |=> proto_err);
endmodule

// File: tb/test_sdram_bank_tracker.sv
`timescale 1ns/1ps
module test_sdram_bank_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd_code = 4'd0;
    logic        bank_sel_msb = 1'b0, bank_sel_lsb = 1'b0;
    logic [12:0] addr = '0;
    logic [3:0]  bank_open;
    logic [51:0] bank_rows;
    logic        mode_valid, proto_err;
    int checks = 0;
    int failures = 0;

    localparam logic [3:0] NOP = 0, ACT = 1, RD = 2, WR = 3, WRAP = 4,
                           PRE = 5, PALL = 6, REF = 7, MRS = 8;

    always #2 clk = ~clk;

    sdram_bank_tracker i_sdram_bank_tracker (
        .clk(clk), .rst(rst), .cmd_code(cmd_code),
        .bank_sel_msb(bank_sel_msb), .bank_sel_lsb(bank_sel_lsb), .addr(addr),
        .bank_open(bank_open), .bank_rows(bank_rows),
        .mode_valid(mode_valid), .proto_err(proto_err));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_code = NOP;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [3:0] c, input int bank, input logic [12:0] a);
        @(negedge clk);
        cmd_code = c;
        bank_sel_msb = bank[1];
        bank_sel_lsb = bank[0];
        addr = a;
        @(negedge clk);
        cmd_code = NOP;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 open after reset", 32'(bank_open), 0);
        check("R1 mode_valid after reset", 32'(mode_valid), 0);
        check("R1 proto_err after reset", 32'(proto_err), 0);
    endtask

    task automatic t_pre_mode();
        do_reset();
        issue(NOP, 0, 0);
        check("R2 NOP before mode", 32'(proto_err), 0);
        issue(ACT, 1, 13'd5);
        check("R2 ACTV before mode err", 32'(proto_err), 1);
        check("R2 ACTV before mode open", 32'(bank_open), 0);
        check("R2 mode still unset", 32'(mode_valid), 0);
    endtask

    task automatic t_mrs();
        do_reset();
        issue(MRS, 0, 13'd5);
        check("R3 bad burst code err", 32'(proto_err), 1);
        check("R3 bad burst code no mode", 32'(mode_valid), 0);
        do_reset();
        issue(MRS, 0, 13'd3);
        check("R3 legal MRS mode_valid", 32'(mode_valid), 1);
        check("R3 legal MRS no err", 32'(proto_err), 0);
        issue(ACT, 0, 13'd9);
        issue(MRS, 0, 13'd1);
        check("R3 MRS with open bank err", 32'(proto_err), 1);
    endtask

    task automatic t_decode();
        logic [3:0] exp_open = 0;
        do_reset();
        issue(MRS, 0, 13'd0);
        for (int b = 0; b < 4; b++) begin
            issue(ACT, b, 13'h1A00 | 13'(b));
            exp_open[b] = 1'b1;
            check("R4 open flag by select", 32'(bank_open), 32'(exp_open));
            check("R5 row latched", 32'(bank_rows[13*b +: 13]), 32'(13'h1A00 | 13'(b)));
        end
        check("R5 no err on legal ACTV", 32'(proto_err), 0);
        issue(ACT, 2, 13'd7);
        check("R5 duplicate ACTV err", 32'(proto_err), 1);
        check("R5 duplicate ACTV row kept", 32'(bank_rows[26 +: 13]), 32'(13'h1A02));
    endtask

    task automatic t_rw();
        do_reset();
        issue(MRS, 0, 13'd0);
        issue(RD, 0, 0);
        check("R6 READ closed bank err", 32'(proto_err), 1);
        do_reset();
        issue(MRS, 0, 13'd0);
        issue(ACT, 0, 13'd3);
        issue(WR, 0, 13'd12);
        issue(RD, 0, 13'd12);
        check("R6 WRIT/READ open bank no err", 32'(proto_err), 0);
        check("R6 bank stays open", 32'(bank_open), 1);
    endtask

    task automatic t_pre_pall();
        do_reset();
        issue(MRS, 0, 13'd0);
        issue(ACT, 0, 13'd1);
        issue(ACT, 3, 13'd2);
        issue(PRE, 3, 0);
        check("R8 PRE closes named bank only", 32'(bank_open), 32'h1);
        issue(PRE, 2, 0);
        check("R8 PRE closed bank no err", 32'(proto_err), 0);
        issue(ACT, 1, 13'd4);
        issue(ACT, 2, 13'd5);
        issue(PALL, 0, 0);
        check("R9 PALL closes all", 32'(bank_open), 0);
        check("R9 PALL no err", 32'(proto_err), 0);
    endtask

    task automatic t_ref();
        do_reset();
        issue(MRS, 0, 13'd0);
        issue(REF, 0, 0);
        check("R10 REF all closed no err", 32'(proto_err), 0);
        check("R10 REF all closed no open", 32'(bank_open), 0);
        issue(ACT, 1, 13'd6);
        issue(REF, 0, 0);
        check("R10 REF with open bank err", 32'(proto_err), 1);
        check("R10 REF leaves bank", 32'(bank_open), 32'h2);
    endtask

    task automatic t_autopre(input logic [12:0] mode, input int len);
        do_reset();
        issue(MRS, 0, mode);
        issue(ACT, 2, 13'd11);
        issue(WRAP, 2, 0);
        check("R7 open after WRITA edge", 32'(bank_open[2]), 1);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            check("R7 open during burst", 32'(bank_open[2]), 1);
        end
        @(negedge clk);
        check("R7 closed after last beat", 32'(bank_open[2]), 0);
        check("R7 no err", 32'(proto_err), 0);
    endtask

    task automatic t_closing_busy();
        do_reset();
        issue(MRS, 0, 13'd3);
        issue(ACT, 2, 13'd11);
        issue(WRAP, 2, 0);
        issue(WR, 2, 0);
        check("R7 WRIT to closing bank err", 32'(proto_err), 1);
    endtask

    task automatic t_illegal_sticky();
        do_reset();
        issue(MRS, 0, 13'd0);
        issue(4'd9, 0, 0);
        check("R12 code 9 err", 32'(proto_err), 1);
        repeat (3) @(negedge clk);
        check("R11 err stays set", 32'(proto_err), 1);
        do_reset();
        check("R11 reset clears err", 32'(proto_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_pre_mode();
        t_mrs();
        t_decode();
        t_rw();
        t_pre_pall();
        t_ref();
        t_autopre(13'd0, 1);
        t_autopre(13'd1, 2);
        t_autopre(13'd2, 4);
        t_autopre(13'd3, 8);
        t_autopre(13'h203, 1);
        t_closing_busy();
        t_illegal_sticky();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule